// File: doc/BRIEF.md
# Time-of-Day Counter with Periodic Drift Correction

This block keeps a free-running time-of-day value for stamping packets. It presents the time in two forms at once. The wide form is a 96-bit word holding whole seconds, nanoseconds within the current second, and a 16-bit fraction of a nanosecond. The narrow form is a 64-bit word holding a running nanosecond count with the same 16-bit fraction. On every clock cycle both forms advance by a programmable period, expressed in nanoseconds plus fractional nanoseconds. The default period of 6.4 ns suits a 156.25 MHz clock; an 8 ns period suits a 125 MHz clock.

Slow drift against a reference is corrected by a second, independent term. A small fractional-nanosecond amount is added on top of the period once every programmable number of cycles. A rate of zero turns the correction off. A load strobe replaces both forms with externally synchronized values. Configuration goes through a narrow write-only port with a two-bit register select.

Top module: `tod_counter`

## Requirements
- R1: While `rst` is high, both outputs are zero. After reset the period is 6 ns plus 0x6666 fractional units, the drift amount is zero and the drift rate is zero.
- R2: On every clock edge without load, the 16-bit fraction and the nanosecond field advance by the period. A carry out of the fraction goes into the nanoseconds.
- R3: When the nanosecond sum reaches 1,000,000,000 or more, that amount is subtracted and seconds increment in the same cycle. The nanosecond field stays below 10^9.
- R4: With drift rate N > 0, the drift amount is added on top of the period on every Nth clock edge, counted from the edge that wrote the rate. For example, 2 units with N = 5 adds 4 units over 10 edges.
- R5: A drift rate of zero adds no drift, whatever the drift amount.
- R6: On an edge with `load` high, `tod96` takes `load_t96` and `tod64` takes `load_t64` exactly, with no increment that cycle. Loaded nanoseconds must be below 10^9. Load does not disturb the drift interval.
- R7: `tod64` is {48-bit nanoseconds, 16-bit fraction}. It advances by the same amount as `tod96` and wraps modulo 2^64. `tod96` is {48-bit seconds, 32-bit nanoseconds, 16-bit fraction}.
- R8: A write with `cfg_wr` high takes effect from the next edge. Select 0 sets the period from `cfg_wdata`, with nanoseconds in [31:16] and fraction in [15:0]. Select 1 sets the drift amount from [15:0]. Select 2 sets the drift rate from [19:0] and restarts the interval. Select 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select (0 period, 1 drift amount, 2 drift rate, 3 none) |
| cfg_wdata | input | 32 | Configuration write data |
| load | input | 1 | Load strobe for synchronized time |
| load_t96 | input | 96 | Time to load, wide form |
| load_t64 | input | 64 | Time to load, narrow form |
| tod96 | output | 96 | Seconds, nanoseconds, fractional nanoseconds |
| tod64 | output | 64 | Nanoseconds, fractional nanoseconds |

## Verification
The bench places the time just below a second boundary and the narrow form just below 2^64. A design with a missing or late rollover would show nanoseconds of 10^9 or more, or seconds that stay put. Fractions near 0xFFFF exercise the carry into nanoseconds, which a design that drops the carry would lose. Drift is checked with rates of 0, 1 and several larger values, and with a rate rewritten part-way through an interval. An off-by-one interval, a free-running interval counter, or a zero rate taken as "every cycle" each move the total by a visible number of drift units. A write to the unused select, combined with a load, shows whether that write disturbs the period or whether the load still lets an increment slip through.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int unsigned NS_PER_SEC = 1_000_000_000;

  typedef enum logic [1:0] {
    SEL_PERIOD = 2'd0,
    SEL_DRIFT  = 2'd1,
    SEL_RATE   = 2'd2,
    SEL_NONE   = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/tod_cfg_regs.sv
module tod_cfg_regs
  import tod_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PER_NS_W = 16,
  parameter int unsigned FRAC_W   = 16,
  parameter int unsigned RATE_W   = 20,
  parameter logic [PER_NS_W-1:0] RST_PER_NS   = 6,
  parameter logic [FRAC_W-1:0]   RST_PER_FRAC = 16'h6666
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [PER_NS_W-1:0] per_ns,
  output logic [FRAC_W-1:0]   per_frac,
  output logic [FRAC_W-1:0]   drift_frac,
  output logic [RATE_W-1:0]   rate,
  output logic                rate_wr
);
  cfg_sel_e sel;
  assign sel     = cfg_sel_e'(wr_sel);
  assign rate_wr = wr_en && (sel == SEL_RATE);

  always_ff @(posedge clk) begin
    if (rst) begin
      per_ns     <= RST_PER_NS;
      per_frac   <= RST_PER_FRAC;
      drift_frac <= '0;
      rate       <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_PERIOD: begin
          per_ns   <= wr_data[FRAC_W +: PER_NS_W];
          per_frac <= wr_data[FRAC_W-1:0];
        end
        SEL_DRIFT: drift_frac <= wr_data[FRAC_W-1:0];
        SEL_RATE:  rate       <= wr_data[RATE_W-1:0];
        default: ;
      endcase
    end
  end

  // R8: the unused select leaves every register as it was
  a_r8_sel_none_noop: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_NONE) |=>
      ($stable(per_ns) && $stable(per_frac) && $stable(drift_frac) && $stable(rate)));
endmodule

// File: rtl/tod_drift_timer.sv
module tod_drift_timer #(
  parameter int unsigned RATE_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rate,
  input  logic              rate_wr,
  output logic              drift_ev
);
  logic [RATE_W-1:0] cnt_q;
  logic              enabled;

  assign enabled  = (rate != '0);
  assign drift_ev = enabled && (cnt_q == rate - RATE_W'(1));

  always_ff @(posedge clk) begin
    if (rst || rate_wr || !enabled || drift_ev) cnt_q <= '0;
    else                                       cnt_q <= cnt_q + RATE_W'(1);
  end

  // R4: with an interval longer than one, two events never come back to back
  a_r4_spaced_events: assert property (@(posedge clk) disable iff (rst)
    (drift_ev && !rate_wr && rate > RATE_W'(1)) |=> !drift_ev);

  // R5: a zero rate keeps the interval counter parked
  a_r5_zero_rate_idle: assert property (@(posedge clk) disable iff (rst)
    (!enabled && !rate_wr) |=> (cnt_q == '0 && !drift_ev));
endmodule

// File: rtl/tod_time_adder.sv
module tod_time_adder
  import tod_pkg::*;
#(
  parameter int unsigned SEC_W    = 48,
  parameter int unsigned NS_W     = 32,
  parameter int unsigned FRAC_W   = 16,
  parameter int unsigned NS64_W   = 48,
  parameter int unsigned PER_NS_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PER_NS_W-1:0] per_ns,
  input  logic [FRAC_W-1:0]   per_frac,
  input  logic [FRAC_W-1:0]   drift_frac,
  input  logic                drift_ev,
  input  logic                load,
  input  logic [SEC_W-1:0]    load_sec,
  input  logic [NS_W-1:0]     load_ns,
  input  logic [FRAC_W-1:0]   load_frac,
  input  logic [NS64_W-1:0]   load_ns64,
  input  logic [FRAC_W-1:0]   load_frac64,
  output logic [SEC_W-1:0]    sec_q,
  output logic [NS_W-1:0]     ns_q,
  output logic [FRAC_W-1:0]   frac_q,
  output logic [NS64_W-1:0]   ns64_q,
  output logic [FRAC_W-1:0]   frac64_q
);
  localparam int unsigned STEP_W = PER_NS_W + FRAC_W + 1;
  localparam int unsigned NADD_W = PER_NS_W + 1;
  localparam logic [NS_W:0] BILLION = (NS_W+1)'(NS_PER_SEC);

  // Period plus optional drift, in fractional-nanosecond units
  function automatic logic [STEP_W-1:0] step_units(
    input logic [PER_NS_W-1:0] pns, input logic [FRAC_W-1:0] pfr,
    input logic [FRAC_W-1:0] dfr, input logic add_drift);
    return {1'b0, pns, pfr} + (add_drift ? STEP_W'(dfr) : '0);
  endfunction

  // Sum of fraction and step fraction, carry in the top bit
  function automatic logic [FRAC_W:0] frac_sum(
    input logic [FRAC_W-1:0] cur, input logic [FRAC_W-1:0] inc);
    return {1'b0, cur} + {1'b0, inc};
  endfunction

  logic [STEP_W-1:0] step;
  logic [FRAC_W:0]   f96, f64;
  logic [NADD_W:0]   nadd96, nadd64;
  logic [NS_W:0]     ns_sum;
  logic              ns_wrap;

  assign step    = step_units(per_ns, per_frac, drift_frac, drift_ev);
  assign f96     = frac_sum(frac_q, step[FRAC_W-1:0]);
  assign f64     = frac_sum(frac64_q, step[FRAC_W-1:0]);
  assign nadd96  = {1'b0, step[STEP_W-1:FRAC_W]} + (NADD_W+1)'(f96[FRAC_W]);
  assign nadd64  = {1'b0, step[STEP_W-1:FRAC_W]} + (NADD_W+1)'(f64[FRAC_W]);
  assign ns_sum  = {1'b0, ns_q} + (NS_W+1)'(nadd96);
  assign ns_wrap = (ns_sum >= BILLION);

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q    <= '0;
      ns_q     <= '0;
      frac_q   <= '0;
      ns64_q   <= '0;
      frac64_q <= '0;
    end else if (load) begin
      sec_q    <= load_sec;
      ns_q     <= load_ns;
      frac_q   <= load_frac;
      ns64_q   <= load_ns64;
      frac64_q <= load_frac64;
    end else begin
      frac_q   <= f96[FRAC_W-1:0];
      frac64_q <= f64[FRAC_W-1:0];
      ns64_q   <= ns64_q + NS64_W'(nadd64);
      if (ns_wrap) begin
        ns_q  <= NS_W'(ns_sum - BILLION);
        sec_q <= sec_q + SEC_W'(1);
      end else begin
        ns_q  <= ns_sum[NS_W-1:0];
      end
    end
  end

  // R3: nanoseconds stay within one second
  a_r3_ns_in_range: assert property (@(posedge clk) disable iff (rst)
    !load |=> ({1'b0, ns_q} < BILLION));

  // R3: seconds move exactly when nanoseconds fall back
  a_r3_sec_with_ns_drop: assert property (@(posedge clk) disable iff (rst)
    !load |=> ((sec_q != $past(sec_q)) == (ns_q < $past(ns_q)))
              && (sec_q == $past(sec_q) || sec_q == $past(sec_q) + SEC_W'(1)));

  // R6: a load copies both forms exactly
  a_r6_load_copy: assert property (@(posedge clk) disable iff (rst)
    load |=> ({sec_q, ns_q, frac_q} == $past({load_sec, load_ns, load_frac})
              && {ns64_q, frac64_q} == $past({load_ns64, load_frac64})));

  // R7: both forms see the same fractional advance
  a_r7_frac_agree: assert property (@(posedge clk) disable iff (rst)
    !load |=> (FRAC_W'(frac64_q - $past(frac64_q)) == FRAC_W'(frac_q - $past(frac_q))));
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int unsigned SEC_W    = 48,
  parameter int unsigned NS_W     = 32,
  parameter int unsigned FRAC_W   = 16,
  parameter int unsigned NS64_W   = 48,
  parameter int unsigned PER_NS_W = 16,
  parameter int unsigned RATE_W   = 20,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned T96_W   = SEC_W + NS_W + FRAC_W,
  localparam int unsigned T64_W   = NS64_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              load,
  input  logic [T96_W-1:0]  load_t96,
  input  logic [T64_W-1:0]  load_t64,
  output logic [T96_W-1:0]  tod96,
  output logic [T64_W-1:0]  tod64
);
  logic [PER_NS_W-1:0] per_ns;
  logic [FRAC_W-1:0]   per_frac, drift_frac, frac_q, frac64_q;
  logic [RATE_W-1:0]   rate;
  logic                rate_wr, drift_ev;
  logic [SEC_W-1:0]    sec_q;
  logic [NS_W-1:0]     ns_q;
  logic [NS64_W-1:0]   ns64_q;

  tod_cfg_regs #(.DATA_W(DATA_W), .PER_NS_W(PER_NS_W), .FRAC_W(FRAC_W), .RATE_W(RATE_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(cfg_wr), .wr_sel(cfg_sel), .wr_data(cfg_wdata),
    .per_ns(per_ns), .per_frac(per_frac), .drift_frac(drift_frac),
    .rate(rate), .rate_wr(rate_wr));

  tod_drift_timer #(.RATE_W(RATE_W)) u_timer (
    .clk(clk), .rst(rst), .rate(rate), .rate_wr(rate_wr), .drift_ev(drift_ev));

  tod_time_adder #(.SEC_W(SEC_W), .NS_W(NS_W), .FRAC_W(FRAC_W), .NS64_W(NS64_W),
                   .PER_NS_W(PER_NS_W)) u_add (
    .clk(clk), .rst(rst), .per_ns(per_ns), .per_frac(per_frac),
    .drift_frac(drift_frac), .drift_ev(drift_ev), .load(load),
    .load_sec(load_t96[T96_W-1 -: SEC_W]), .load_ns(load_t96[FRAC_W +: NS_W]),
    .load_frac(load_t96[FRAC_W-1:0]), .load_ns64(load_t64[T64_W-1 -: NS64_W]),
    .load_frac64(load_t64[FRAC_W-1:0]),
    .sec_q(sec_q), .ns_q(ns_q), .frac_q(frac_q), .ns64_q(ns64_q), .frac64_q(frac64_q));

  assign tod96 = {sec_q, ns_q, frac_q};
  assign tod64 = {ns64_q, frac64_q};

  // R1: outputs read zero on the edge after reset is sampled
  a_r1_reset_zero: assert property (@(posedge clk)
    $past(rst) |-> (tod96 == '0 && tod64 == '0));
endmodule

// File: tb/tb_tod_counter.sv
module tb_tod_counter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        load = 1'b0;
  logic [95:0] load_t96 = '0;
  logic [63:0] load_t64 = '0;
  logic [95:0] tod96;
  logic [63:0] tod64;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  tod_counter dut (.clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .load(load), .load_t96(load_t96), .load_t64(load_t64),
    .tod96(tod96), .tod64(tod64));

  typedef struct packed {
    logic [31:0] per;
    logic [15:0] drift;
    logic [19:0] rate;
    logic [15:0] ncyc;
    logic [47:0] sec;
    logic [31:0] ns;
    logic [15:0] frac;
    logic [63:0] l64;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h0006_6666, 16'h0002, 20'd5, 16'd10, 48'd0,            32'd0,           16'h0000, 64'h0},
    '{32'h0008_0000, 16'h0100, 20'd0, 16'd20, 48'd5,            32'd100,         16'h0000, 64'h1234},
    '{32'h0006_6666, 16'h0000, 20'd0, 16'd3,  48'd7,            32'd999_999_990, 16'hF000, 64'hFFFF_FFFF_FFFF_FFF0},
    '{32'h0000_8000, 16'h8000, 20'd1, 16'd9,  48'd0,            32'd0,           16'h0000, 64'h0},
    '{32'h0003_0000, 16'hFFFF, 20'd7, 16'd50, 48'hFFFF_FFFF_FFFE, 32'd999_999_000, 16'h0001, 64'h55},
    '{32'h0010_0001, 16'h0003, 20'd4, 16'd4,  48'd9,            32'd999_999_999, 16'hFFFF, 64'hFFFF}
  };

  localparam logic [127:0] UNITS_PER_SEC = 128'd1_000_000_000 << 16;

  // Total fractional units accumulated over n edges, per the requirements
  function automatic logic [127:0] advance(input logic [127:0] base, input logic [31:0] per,
    input logic [15:0] d, input logic [19:0] rate, input int n);
    logic [127:0] k;
    k = (rate == 0) ? 128'd0 : 128'(n / int'(rate));
    return base + 128'(n) * 128'(per) + k * 128'(d);
  endfunction

  function automatic logic [127:0] from96(input logic [95:0] t);
    return 128'(t[95:48]) * UNITS_PER_SEC + 128'(t[47:16]) * 128'd65536 + 128'(t[15:0]);
  endfunction

  function automatic logic [95:0] to96(input logic [127:0] f);
    logic [127:0] s, ns;
    s  = f / UNITS_PER_SEC;
    ns = (f >> 16) % 128'd1_000_000_000;
    return {s[47:0], ns[31:0], f[15:0]};
  endfunction

  task automatic chk96(input string req, input logic [95:0] exp);
    checks++;
    if (tod96 !== exp) begin
      errors++;
      $display("FAIL %s tod96 actual %h expected %h", req, tod96, exp);
    end
  endtask

  task automatic chk64(input string req, input logic [63:0] exp);
    checks++;
    if (tod64 !== exp) begin
      errors++;
      $display("FAIL %s tod64 actual %h expected %h", req, tod64, exp);
    end
  endtask

  // Starts and ends at a falling edge; the last setup edge writes rate and loads
  task automatic setup(input logic [31:0] per, input logic [15:0] d, input logic [19:0] rate,
    input logic [95:0] t96, input logic [63:0] t64);
    cfg_wr = 1'b1; cfg_sel = 2'd0; cfg_wdata = per;
    @(negedge clk);
    cfg_sel = 2'd1; cfg_wdata = {16'h0, d};
    @(negedge clk);
    cfg_sel = 2'd2; cfg_wdata = {12'h0, rate};
    load = 1'b1; load_t96 = t96; load_t64 = t64;
    @(negedge clk);
    cfg_wr = 1'b0; load = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [95:0] t96;
    logic [127:0] f;
    repeat (3) @(negedge clk);
    chk96("R1 reset", 96'h0);
    chk64("R1 reset", 64'h0);
    rst = 1'b0;
    @(negedge clk);
    chk96("R1 R2 default period", {48'd0, 32'd6, 16'h6666});
    repeat (10) @(negedge clk);
    f = advance(128'd0, 32'h0006_6666, 16'h0, 20'd0, 11);
    chk96("R1 R5 default drift off", to96(f));
    chk64("R7 default", f[63:0]);

    for (int i = 0; i < 6; i++) begin
      t96 = {VECS[i].sec, VECS[i].ns, VECS[i].frac};
      setup(VECS[i].per, VECS[i].drift, VECS[i].rate, t96, VECS[i].l64);
      chk96($sformatf("R6 load vec%0d", i), t96);
      chk64($sformatf("R6 load vec%0d", i), VECS[i].l64);
      repeat (int'(VECS[i].ncyc)) @(negedge clk);
      f = advance(from96(t96), VECS[i].per, VECS[i].drift, VECS[i].rate, int'(VECS[i].ncyc));
      chk96($sformatf("R2 R3 R4 R5 vec%0d", i), to96(f));
      f = advance(128'(VECS[i].l64), VECS[i].per, VECS[i].drift, VECS[i].rate, int'(VECS[i].ncyc));
      chk64($sformatf("R7 R4 vec%0d", i), f[63:0]);
    end

    // R8: select 3 write alongside a load; period must be untouched, load exact
    t96 = {48'd3, 32'd500, 16'h0};
    setup(32'h0002_0000, 16'h0, 20'd0, 96'h0, 64'h0);
    cfg_wr = 1'b1; cfg_sel = 2'd3; cfg_wdata = 32'hFFFF_FFFF;
    load = 1'b1; load_t96 = t96; load_t64 = 64'h10;
    @(negedge clk);
    cfg_wr = 1'b0; load = 1'b0;
    chk96("R6 R8 load with sel3", t96);
    repeat (5) @(negedge clk);
    chk96("R8 sel3 ignored", to96(advance(from96(t96), 32'h0002_0000, 16'h0, 20'd0, 5)));
    chk64("R8 sel3 ignored", 64'h10 + 64'd5 * 64'h0002_0000);

    // R4 R8: rewriting the rate part-way through restarts the interval
    t96 = {48'd1, 32'd0, 16'h0};
    setup(32'h0001_0000, 16'h1000, 20'd4, t96, 64'h0);
    repeat (2) @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = 2'd2; cfg_wdata = 32'd4;
    @(negedge clk);
    cfg_wr = 1'b0;
    repeat (3) @(negedge clk);
    chk96("R4 R8 restart no drift yet", to96(from96(t96) + 128'd6 * 128'h1_0000));
    @(negedge clk);
    chk96("R4 R8 restart drift", to96(from96(t96) + 128'd7 * 128'h1_0000 + 128'h1000));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule